// File: doc/BRIEF.md
# Temperature Monitor Control Register Bank with Set/Clear/Toggle Aliases

This block is the software-visible register bank of an on-chip temperature monitor. A small synchronous bus (word address, write strobe, write data, registered read data) reaches six 32-bit registers. Each register takes up a 16-byte slot. The slot's first word is the plain register. The next three words are alias views that OR, AND-NOT or XOR the written data into the stored value. Software can therefore change chosen bits in one write, with no read-modify-write.

The bank drives the monitor's control fields as plain pins. These are the alarm comparator set-up, the alarm threshold, the measurement enable, mode and resolution, the measurement period and the reference divider. It sends one-cycle start and stop requests to the measurement sequencer. It also keeps two event flags raised by hardware, an alarm event and a data-ready event. Software clears each flag by writing a 1 through the clear alias of the status register. Reads return the stored value from any of the four words of a slot, one cycle after the address is presented.

Top module: `tsm_csr_bank`

## Requirements
- R1: A write to a slot's first word (bits [3:2] = 0) replaces the register with the write data, limited to that register's implemented bits.
- R2: A write to slot word +0x4 sets every register bit whose write-data bit is 1 and leaves the others unchanged.
- R3: A write to slot word +0x8 clears every register bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to slot word +0xC inverts every register bit whose write-data bit is 1 and leaves the others unchanged.
- R5: `bus_rdata` shows, one clock after an address is presented, the value of the register selected by address bits [ADDR_W-1:4], whichever alias word is used; address bits [1:0] are ignored.
- R6: Bits a register does not implement read as 0 and ignore writes. Addresses that match no slot read as 0, and writes to them change nothing. Implemented bits: alarm config 0x000 -> 0x0000_020C; status 0x010 -> 0x0001_2200; threshold 0x030 -> 0xFFFF_0000; measurement control 0x200 -> 0x830C_0000 stored plus pulse bits 30 and 29; period 0x270 -> 0x00FF_FFFF; divider 0x280 -> 0x80FF_0000.
- R7: After reset every register reads 0, except the period register at 0x270, which reads 0x0002_7100.
- R8: In the register at 0x200, bit 30 is a start request and bit 29 a stop request. A write through the base, set or toggle word with that bit at 1 gives one high cycle on `start_pulse` / `stop_pulse` in the cycle after the write edge. A write through the clear word gives none. Both bits always read back as 0.
- R9: Status register 0x010 holds the alarm flag at bit 9 and the data-ready flag at bit 16. Each is set by a one-cycle high on `hw_alarm_evt` / `hw_ready_evt`. It is cleared only by writing 1 to it through the clear word 0x018. Writes through the other three words leave the flags unchanged. A hardware set and a clear in the same cycle leave the flag set.
- R10: Status bit 13 reads the live level of `alarm_level` at the time of the read and cannot be written.
- R11: `irq` is high exactly when the alarm flag (status bit 9) and the alarm enable (bit 9 of 0x000) are both 1.
- R12: Field pins follow the stored bits. `cmp_mode` = 0x000[3:2], `alarm_ie` = 0x000[9], `thresh` = 0x030[31:16], `mon_en` = 0x200[31], `meas_mode` = 0x200[25:24], `res_sel` = 0x200[19:18], `period` = 0x270[23:0], `div_en` = 0x280[31], `div_val` = 0x280[23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| hw_alarm_evt | input | 1 | Sets the alarm flag |
| hw_ready_evt | input | 1 | Sets the data-ready flag |
| alarm_level | input | 1 | Live comparator level, seen at status bit 13 |
| mon_en | output | 1 | Monitor enable |
| start_pulse | output | 1 | One-cycle start request |
| stop_pulse | output | 1 | One-cycle stop request |
| meas_mode | output | 2 | Measurement mode |
| res_sel | output | 2 | Resolution select |
| alarm_ie | output | 1 | Alarm interrupt enable |
| cmp_mode | output | 2 | Alarm comparator mode |
| thresh | output | 16 | Alarm threshold |
| period | output | 24 | Periodic measurement interval |
| div_en | output | 1 | Reference divider enable |
| div_val | output | 8 | Reference divider value |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that every input holds a known 0 or 1 from reset onward. They take each `bus_we` high cycle as one complete write whose address and data are sampled at that edge, and they take the event inputs as already synchronous to `clk`. The stimulus changes every input only at the falling edge. It raises `bus_we` and the event inputs for single cycles. It holds `alarm_level` steady around each status read, so the live bit and the read-data property see the same value.

// File: rtl/tsm_csr_pkg.sv
package tsm_csr_pkg;

  localparam int CSR_DW   = 32;
  localparam int NUM_REGS = 6;
  localparam int SLOT_LSB = 4;   // slot index starts at this address bit
  localparam int OP_LSB   = 2;   // alias word select bits [3:2]

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;

  typedef enum logic {
    KIND_RW  = 1'b0,
    KIND_W1C = 1'b1
  } reg_kind_e;

  localparam int IDX_ALARM  = 0;
  localparam int IDX_STATUS = 1;
  localparam int IDX_THRESH = 2;
  localparam int IDX_MEAS   = 3;
  localparam int IDX_PERIOD = 4;
  localparam int IDX_DIV    = 5;

  // bit positions the rest of the monitor decodes
  localparam int BIT_ALARM_FLAG = 9;
  localparam int BIT_LIVE_LEVEL = 13;
  localparam int BIT_READY_FLAG = 16;
  localparam int BIT_START      = 30;
  localparam int BIT_STOP       = 29;

  function automatic logic [11:0] reg_ofs(input int idx);
    case (idx)
      IDX_ALARM:  return 12'h000;
      IDX_STATUS: return 12'h010;
      IDX_THRESH: return 12'h030;
      IDX_MEAS:   return 12'h200;
      IDX_PERIOD: return 12'h270;
      default:    return 12'h280;
    endcase
  endfunction

  function automatic logic [CSR_DW-1:0] reg_mask(input int idx);
    case (idx)
      IDX_ALARM:  return 32'h0000_020C;
      IDX_STATUS: return 32'h0001_0200;
      IDX_THRESH: return 32'hFFFF_0000;
      IDX_MEAS:   return 32'h830C_0000;
      IDX_PERIOD: return 32'h00FF_FFFF;
      default:    return 32'h80FF_0000;
    endcase
  endfunction

  function automatic logic [CSR_DW-1:0] reg_rst(input int idx);
    return (idx == IDX_PERIOD) ? 32'h0002_7100 : 32'h0;
  endfunction

  function automatic reg_kind_e reg_kind(input int idx);
    return (idx == IDX_STATUS) ? KIND_W1C : KIND_RW;
  endfunction

endpackage

// File: rtl/tsm_alias_decode.sv
module tsm_alias_decode
  import tsm_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:OP_LSB] addr,
  output logic [NUM_REGS-1:0]    sel,
  output alias_op_e              op
);

  localparam int SLOT_W = ADDR_W - SLOT_LSB;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
    localparam logic [SLOT_W-1:0] SLOT_ID = SLOT_W'(reg_ofs(i) >> SLOT_LSB);
    assign sel[i] = (addr[ADDR_W-1:SLOT_LSB] == SLOT_ID);
  end

  assign op = alias_op_e'(addr[SLOT_LSB-1:OP_LSB]);

endmodule

// File: rtl/tsm_csr_cell.sv
module tsm_csr_cell
  import tsm_csr_pkg::*;
#(
  parameter int               DW   = 32,
  parameter logic [DW-1:0]    MASK = '1,
  parameter logic [DW-1:0]    RST  = '0,
  parameter reg_kind_e        KIND = KIND_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  alias_op_e     op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);

  logic [DW-1:0] nxt;

  if (KIND == KIND_W1C) begin : g_w1c
    logic [DW-1:0] cleared;
    always_comb begin
      cleared = (wr && op == OP_CLR) ? (q & ~wdata) : q;
      nxt     = cleared | hw_set;   // a hardware event wins over a clear
    end
  end else begin : g_rw
    logic unused_hw;
    assign unused_hw = ^hw_set;
    always_comb begin
      nxt = q;
      if (wr) begin
        case (op)
          OP_BASE: nxt = wdata;
          OP_SET:  nxt = q | wdata;
          OP_CLR:  nxt = q & ~wdata;
          default: nxt = q ^ wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST & MASK;
    else        q <= nxt & MASK;
  end

endmodule

// File: rtl/tsm_readback.sv
module tsm_readback
  import tsm_csr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REGS-1:0]          sel,
  input  logic [NUM_REGS-1:0][DW-1:0]  vals,
  output logic [DW-1:0]                rdata
);

  logic [DW-1:0] mux;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      mux = mux | (vals[i] & {DW{sel[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mux;
  end

endmodule

// File: rtl/tsm_csr_bank.sv
module tsm_csr_bank
  import tsm_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_alarm_evt,
  input  logic              hw_ready_evt,
  input  logic              alarm_level,
  output logic              mon_en,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic [1:0]        meas_mode,
  output logic [1:0]        res_sel,
  output logic              alarm_ie,
  output logic [1:0]        cmp_mode,
  output logic [15:0]       thresh,
  output logic [23:0]       period,
  output logic              div_en,
  output logic [7:0]        div_val,
  output logic              irq
);

  localparam int DW = CSR_DW;

  logic [NUM_REGS-1:0]         sel;
  logic [NUM_REGS-1:0]         wr_hit;
  alias_op_e                   op;
  logic [NUM_REGS-1:0][DW-1:0] q;
  logic [NUM_REGS-1:0][DW-1:0] hw_set;
  logic [NUM_REGS-1:0][DW-1:0] rb_vals;
  logic                        unused_addr_lo;

  assign unused_addr_lo = ^bus_addr[OP_LSB-1:0];

  tsm_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr[ADDR_W-1:OP_LSB]),
    .sel  (sel),
    .op   (op)
  );

  assign wr_hit = sel & {NUM_REGS{bus_we}};

  always_comb begin
    hw_set = '0;
    hw_set[IDX_STATUS][BIT_ALARM_FLAG] = hw_alarm_evt;
    hw_set[IDX_STATUS][BIT_READY_FLAG] = hw_ready_evt;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    tsm_csr_cell #(
      .DW   (DW),
      .MASK (reg_mask(i)),
      .RST  (reg_rst(i)),
      .KIND (reg_kind(i))
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_hit[i]),
      .op     (op),
      .wdata  (bus_wdata),
      .hw_set (hw_set[i]),
      .q      (q[i])
    );
  end

  // the live comparator level is merged into the status word on read
  always_comb begin
    rb_vals = q;
    rb_vals[IDX_STATUS][BIT_LIVE_LEVEL] = alarm_level;
  end

  tsm_readback #(.DW(DW)) u_rb (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .vals  (rb_vals),
    .rdata (bus_rdata)
  );

  // start/stop requests: stored value is always 0, so base, set and toggle
  // all raise the bit; the clear word never does
  logic req_ok;
  assign req_ok = wr_hit[IDX_MEAS] && (op != OP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      start_pulse <= req_ok && bus_wdata[BIT_START];
      stop_pulse  <= req_ok && bus_wdata[BIT_STOP];
    end
  end

  assign cmp_mode  = q[IDX_ALARM][3:2];
  assign alarm_ie  = q[IDX_ALARM][9];
  assign thresh    = q[IDX_THRESH][31:16];
  assign mon_en    = q[IDX_MEAS][31];
  assign meas_mode = q[IDX_MEAS][25:24];
  assign res_sel   = q[IDX_MEAS][19:18];
  assign period    = q[IDX_PERIOD][23:0];
  assign div_en    = q[IDX_DIV][31];
  assign div_val   = q[IDX_DIV][23:16];
  assign irq       = alarm_ie && q[IDX_STATUS][BIT_ALARM_FLAG];

endmodule

// File: rtl/tsm_csr_bank_chk.sv
module tsm_csr_bank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              hw_alarm_evt,
  input logic              alarm_level,
  input logic              start_pulse,
  input logic              stop_pulse,
  input logic              alarm_ie,
  input logic [15:0]       thresh,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] A_TH   = ADDR_W'(12'h030);
  localparam logic [ADDR_W-5:0] S_TH   = ADDR_W'(12'h030) >> 4;
  localparam logic [ADDR_W-5:0] S_ST   = ADDR_W'(12'h010) >> 4;
  localparam logic [ADDR_W-5:0] S_MEAS = ADDR_W'(12'h200) >> 4;

  logic th_wr, meas_req;
  assign th_wr    = bus_we && (bus_addr[ADDR_W-1:4] == S_TH);
  assign meas_req = bus_we && (bus_addr[ADDR_W-1:4] == S_MEAS) && (bus_addr[3:2] != 2'd2);

  AST_BASE_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(th_wr && bus_addr[3:2] == 2'd0) |-> thresh == $past(bus_wdata[31:16])); // R1
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(th_wr && bus_addr[3:2] == 2'd1) |-> thresh == ($past(thresh) | $past(bus_wdata[31:16]))); // R2
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(th_wr && bus_addr[3:2] == 2'd2) |-> thresh == ($past(thresh) & ~$past(bus_wdata[31:16]))); // R3
  AST_TOG_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(th_wr && bus_addr[3:2] == 2'd3) |-> thresh == ($past(thresh) ^ $past(bus_wdata[31:16]))); // R4
  AST_TH_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(th_wr) |-> $stable(thresh)); // R6
  AST_TH_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr[ADDR_W-1:4] == S_TH) |-> bus_rdata[15:0] == 16'h0); // R6
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(meas_req && bus_wdata[30])); // R8
  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> $past(meas_req && bus_wdata[29])); // R8
  AST_REQ_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr[ADDR_W-1:4] == S_MEAS) |-> bus_rdata[30:29] == 2'b00); // R8
  AST_LIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr[ADDR_W-1:4] == S_ST) |-> bus_rdata[13] == $past(alarm_level)); // R10
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hw_alarm_evt) && alarm_ie) |-> irq); // R11
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_ie); // R11

  logic unused_a;
  assign unused_a = (A_TH == '0);

endmodule

bind tsm_csr_bank tsm_csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .hw_alarm_evt (hw_alarm_evt),
  .alarm_level  (alarm_level),
  .start_pulse  (start_pulse),
  .stop_pulse   (stop_pulse),
  .alarm_ie     (alarm_ie),
  .thresh       (thresh),
  .irq          (irq)
);

// File: tb/tsm_csr_bank_tb.sv
`timescale 1ns/1ps
module tsm_csr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_alarm_evt = 1'b0, hw_ready_evt = 1'b0, alarm_level = 1'b0;
  logic        mon_en, start_pulse, stop_pulse, alarm_ie, div_en, irq;
  logic [1:0]  meas_mode, res_sel, cmp_mode;
  logic [15:0] thresh;
  logic [23:0] period;
  logic [7:0]  div_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsm_csr_bank #(.ADDR_W(12)) u_dut (.*);

  // register map as given in the requirements
  logic [11:0] ofs  [6] = '{12'h000, 12'h010, 12'h030, 12'h200, 12'h270, 12'h280};
  logic [31:0] msk  [6] = '{32'h0000_020C, 32'h0001_0200, 32'hFFFF_0000,
                            32'h830C_0000, 32'h00FF_FFFF, 32'h80FF_0000};
  logic [31:0] model[6];
  logic        got_start, got_stop;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    got_start = start_pulse;
    got_stop  = stop_pulse;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic check_fields();
    chk("R12 cmp_mode",  {30'd0, cmp_mode},  {30'd0, model[0][3:2]});
    chk("R12 alarm_ie",  {31'd0, alarm_ie},  {31'd0, model[0][9]});
    chk("R12 thresh",    {16'd0, thresh},    {16'd0, model[2][31:16]});
    chk("R12 mon_en",    {31'd0, mon_en},    {31'd0, model[3][31]});
    chk("R12 meas_mode", {30'd0, meas_mode}, {30'd0, model[3][25:24]});
    chk("R12 res_sel",   {30'd0, res_sel},   {30'd0, model[3][19:18]});
    chk("R12 period",    {8'd0, period},     {8'd0, model[4][23:0]});
    chk("R12 div",       {23'd0, div_en, div_val}, {23'd0, model[5][31], model[5][23:16]});
  endtask

  function automatic logic [31:0] apply(input int op, input logic [31:0] cur,
                                        input logic [31:0] d, input logic [31:0] m);
    logic [31:0] r;
    case (op)
      0: r = d;
      1: r = cur | d;
      2: r = cur & ~d;
      default: r = cur ^ d;
    endcase
    return r & m;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] pats [5] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0F0F_F0F0,
                              32'h6000_0000, 32'h1234_5678};

    for (int i = 0; i < 6; i++) model[i] = (i == 4) ? 32'h0002_7100 : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset values
    for (int i = 0; i < 6; i++) begin
      do_read(ofs[i], v);
      chk("R7 reset value", v, model[i]);
    end
    chk("R7 reset pulses/irq", {29'd0, start_pulse, stop_pulse, irq}, 32'h0);
    check_fields();

    // R1-R4, R5, R8, R12: sweep every read/write register, alias and pattern
    for (int r = 0; r < 6; r++) begin
      if (r == 1) continue;
      for (int op = 0; op < 4; op++) begin
        for (int p = 0; p < 5; p++) begin
          logic [31:0] d;
          logic [11:0] ra;
          d = pats[p] ^ {r[7:0], op[7:0], p[7:0], 8'h00};
          do_write(ofs[r] + 12'(op * 4), d);
          model[r] = apply(op, model[r], d, msk[r]);
          if (r == 3) begin
            chk("R8 start pulse", {31'd0, got_start}, {31'd0, (op != 2) && d[30]});
            chk("R8 stop pulse",  {31'd0, got_stop},  {31'd0, (op != 2) && d[29]});
            @(negedge clk);
            chk("R8 pulse one cycle", {30'd0, start_pulse, stop_pulse}, 32'h0);
          end
          // read through a rotating alias word and low address bits
          ra = ofs[r] + 12'(((op + p) % 4) * 4) + 12'(p % 4);
          do_read(ra, v);
          case (op)
            0: chk("R1 base write", v, model[r]);
            1: chk("R2 set alias", v, model[r]);
            2: chk("R3 clear alias", v, model[r]);
            default: chk("R4 toggle alias", v, model[r]);
          endcase
          chk("R5 read via alias", v, model[r]);
          check_fields();
        end
      end
    end

    // R6 unmapped address: reads 0, writes change nothing
    do_write(12'h100, 32'hFFFF_FFFF);
    do_write(12'h2F4, 32'hFFFF_FFFF);
    do_read(12'h100, v);
    chk("R6 unmapped read", v, 32'h0);
    for (int i = 0; i < 6; i++) begin
      if (i == 1) continue;
      do_read(ofs[i], v);
      chk("R6 unmapped write no effect", v, model[i]);
    end

    // status register: R9, R10, R11
    do_write(12'h000, 32'h0000_0200);   // alarm enable on
    model[0] = 32'h0000_0200;
    do_read(12'h010, v);
    chk("R9 flags clear", v, 32'h0);
    chk("R11 irq low without flag", {31'd0, irq}, 32'h0);

    @(negedge clk); hw_alarm_evt = 1'b1;
    @(negedge clk); hw_alarm_evt = 1'b0;
    chk("R11 irq on alarm", {31'd0, irq}, 32'h1);
    @(negedge clk); hw_ready_evt = 1'b1;
    @(negedge clk); hw_ready_evt = 1'b0;
    do_read(12'h010, v);
    chk("R9 both flags set", v, 32'h0001_0200);

    do_write(12'h010, 32'h0);
    do_write(12'h014, 32'hFFFF_FFFF);
    do_write(12'h01C, 32'h0001_0200);
    do_read(12'h01C, v);
    chk("R9 non-clear words ignored", v, 32'h0001_0200);

    do_write(12'h018, 32'h0000_0200);
    do_read(12'h010, v);
    chk("R9 clear alarm flag", v, 32'h0001_0000);
    chk("R11 irq drops", {31'd0, irq}, 32'h0);

    // hardware set and software clear in the same cycle
    @(negedge clk);
    bus_addr = 12'h018; bus_we = 1'b1; bus_wdata = 32'h0001_0200; hw_alarm_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; hw_alarm_evt = 1'b0;
    do_read(12'h010, v);
    chk("R9 set wins over clear", v, 32'h0000_0200);

    do_write(12'h008, 32'h0000_0200);   // alarm enable off
    model[0] = 32'h0;
    chk("R11 irq gated by enable", {31'd0, irq}, 32'h0);

    alarm_level = 1'b1;
    do_write(12'h018, 32'hFFFF_FFFF);   // attempt to clear live bit and flag
    do_read(12'h014, v);
    chk("R10 live level high", v, 32'h0000_2000);
    alarm_level = 1'b0;
    do_read(12'h010, v);
    chk("R10 live level low", v, 32'h0);
    check_fields();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule